// File: doc/BRIEF.md
# Load/Store Requester Port Controller

This block sits between a simple command source and a memory-side responder. It turns one load or store command into the responder's two-phase port handshake. The address is offered first. The data moves only after the responder accepts that address. At the end the block returns one completion pulse that carries the load data, a store-done flag or an error flag.

Only one transaction is in flight at a time. The command side uses a valid/ready handshake. Ready is offered only when the controller is idle and the responder reports that it is not busy. On acceptance the address, the store data and the operation kind are captured into holding registers. The port is then driven from those registers, so the command source is free to change its bus at once.

The state machine has five states. IDLE goes to WAIT_ADDR when a command is accepted. WAIT_ADDR has three exits: to IDLE on an address exception, to SEND_STORE on address acceptance for a store, and to WAIT_LOAD on address acceptance for a load. SEND_STORE always goes to WAIT_NOT_BUSY. WAIT_LOAD goes to IDLE when the load-valid pulse arrives. WAIT_NOT_BUSY goes to IDLE once busy is low. The responder's die input follows the block's synchronous reset.

Top module: `ldst_req_port`

## Requirements
- R1: `cmd_ready` is 1 only in IDLE while `prt_busy` is 0, and a command is accepted only on a cycle where both `cmd_valid` and `cmd_ready` are 1. A `cmd_valid` on any other cycle has no effect: nothing is driven on the port and no response is produced.
- R2: A load command drives only `prt_ld`, and a store command drives only `prt_st`. The two strobes are never 1 together. A strobe rises on the cycle after acceptance and stays high in WAIT_ADDR, and then in WAIT_LOAD (load) or SEND_STORE (store).
- R3: `prt_addr_vld` and `prt_addr` are presented together from the cycle after acceptance. While the responder is busy they stay asserted, with `prt_addr` unchanged.
- R4: `prt_addr_ok` and `prt_addr_exc` are single-cycle pulses. The controller acts on the cycle they are high, for any delay between acceptance and the pulse.
- R5: For a store, `prt_sdata_vld` is 1 for exactly one cycle: the cycle after `prt_addr_ok`, carrying the captured store data on `prt_sdata`.
- R6: When `prt_addr_exc` is seen in WAIT_ADDR, the controller goes to IDLE. On the next cycle it gives a completion with `rsp_error`=1 and `rsp_rdata`=0.
- R7: For a load, `prt_ld_data` is captured on the cycle `prt_ld_ok` is 1, after any delay. On the next cycle a completion appears with `rsp_is_store`=0, `rsp_error`=0 and `rsp_rdata` equal to the captured value.
- R8: For a store, once the data pulse is sent, the controller waits for `prt_busy` to be 0. One cycle later it gives a completion with `rsp_is_store`=1, `rsp_error`=0 and `rsp_rdata`=0.
- R9: While `rst` is 1, `prt_die` is 1. After reset the controller is in IDLE, with all strobes, `prt_addr_vld`, `prt_sdata_vld` and `rsp_valid` at 0.
- R10: `rsp_valid` is a one-cycle pulse, given once for each accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_is_store | input | 1 | 1 = store, 0 = load |
| cmd_addr | input | AW | Command address |
| cmd_wdata | input | DW | Store data |
| rsp_valid | output | 1 | Completion pulse |
| rsp_error | output | 1 | Completion ended by address exception |
| rsp_is_store | output | 1 | Completion belongs to a store |
| rsp_rdata | output | DW | Load data (0 for store or error) |
| prt_ld | output | 1 | Load strobe to responder |
| prt_st | output | 1 | Store strobe to responder |
| prt_die | output | 1 | Abort to responder, follows reset |
| prt_addr_vld | output | 1 | Address valid |
| prt_addr | output | AW | Address held for the transaction |
| prt_sdata_vld | output | 1 | Store data pulse |
| prt_sdata | output | DW | Store data |
| prt_busy | input | 1 | Responder busy |
| prt_addr_ok | input | 1 | Address accepted pulse |
| prt_addr_exc | input | 1 | Address exception pulse |
| prt_ld_ok | input | 1 | Load data valid pulse |
| prt_ld_data | input | DW | Load data |

## Verification
The responder model varies the delay before address acceptance and the delay before load data, including zero delays, so that a wrong sampling cycle separates from a correct one. The model drives the inverse of the expected data outside the load-valid cycle, so capturing data on any other cycle shows up as a mismatch. The command patterns are a store followed by a load of the same address, loads and stores ending in an exception, and back-to-back stores that overwrite one address. Further patterns hold `cmd_valid` during a transaction or while the responder is busy, which shows whether an extra acceptance slips through.

// File: rtl/ldst_req_pkg.sv
package ldst_req_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_ADDR,
        S_SEND_STORE,
        S_WAIT_LOAD,
        S_WAIT_NOT_BUSY
    } req_state_e;

    typedef enum logic [1:0] {
        DONE_NONE,
        DONE_LOAD,
        DONE_STORE,
        DONE_FAULT
    } done_kind_e;

endpackage

// File: rtl/ldst_req_hold.sv
module ldst_req_hold #(
    parameter int AW = 48,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic          in_is_store,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_wdata,
    output logic          hold_is_store,
    output logic [AW-1:0] hold_addr,
    output logic [DW-1:0] hold_wdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_is_store <= 1'b0;
            hold_addr     <= '0;
            hold_wdata    <= '0;
        end else if (capture) begin
            hold_is_store <= in_is_store;
            hold_addr     <= in_addr;
            hold_wdata    <= in_wdata;
        end
    end

endmodule

// File: rtl/ldst_req_ctrl.sv
module ldst_req_ctrl
    import ldst_req_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic       op_store,
    input  logic       busy,
    input  logic       addr_ok,
    input  logic       addr_exc,
    input  logic       ld_ok,
    output logic       cmd_ready,
    output logic       capture,
    output logic       ld_strobe,
    output logic       st_strobe,
    output logic       addr_vld,
    output logic       sdata_vld,
    output done_kind_e done
);

    req_state_e state_q;
    req_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        done    = DONE_NONE;
        capture = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid && !busy) begin
                    capture = 1'b1;
                    state_d = S_WAIT_ADDR;
                end
            end
            S_WAIT_ADDR: begin
                if (addr_exc) begin
                    done    = DONE_FAULT;
                    state_d = S_IDLE;
                end else if (addr_ok) begin
                    state_d = op_store ? S_SEND_STORE : S_WAIT_LOAD;
                end
            end
            S_SEND_STORE: begin
                state_d = S_WAIT_NOT_BUSY;
            end
            S_WAIT_LOAD: begin
                if (ld_ok) begin
                    done    = DONE_LOAD;
                    state_d = S_IDLE;
                end
            end
            S_WAIT_NOT_BUSY: begin
                if (!busy) begin
                    done    = DONE_STORE;
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready = 1'b0;
        ld_strobe = 1'b0;
        st_strobe = 1'b0;
        addr_vld  = 1'b0;
        sdata_vld = 1'b0;
        unique case (state_q)
            S_IDLE: cmd_ready = !busy;
            S_WAIT_ADDR: begin
                ld_strobe = !op_store;
                st_strobe = op_store;
                addr_vld  = 1'b1;
            end
            S_SEND_STORE: begin
                st_strobe = 1'b1;
                addr_vld  = 1'b1;
                sdata_vld = 1'b1;
            end
            S_WAIT_LOAD: begin
                ld_strobe = 1'b1;
                addr_vld  = 1'b1;
            end
            S_WAIT_NOT_BUSY: addr_vld = 1'b1;
            default: ;
        endcase
    end

    a_r5_data_after_accept: assert property (@(posedge clk) disable iff (rst)
        sdata_vld |-> $past(addr_ok));

    a_r5_data_one_cycle: assert property (@(posedge clk) disable iff (rst)
        sdata_vld |=> !sdata_vld);

    a_r6_exc_to_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WAIT_ADDR && addr_exc) |=> (state_q == S_IDLE && !addr_vld));

    a_r2_strobe_after_cmd: assert property (@(posedge clk) disable iff (rst)
        $rose(ld_strobe || st_strobe) |-> $past(cmd_valid));

endmodule

// File: rtl/ldst_req_resp.sv
module ldst_req_resp
    import ldst_req_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  done_kind_e    done,
    input  logic [DW-1:0] ld_data,
    output logic          rsp_valid,
    output logic          rsp_error,
    output logic          rsp_is_store,
    output logic [DW-1:0] rsp_rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_error    <= 1'b0;
            rsp_is_store <= 1'b0;
            rsp_rdata    <= '0;
        end else begin
            rsp_valid    <= (done != DONE_NONE);
            rsp_error    <= (done == DONE_FAULT);
            rsp_is_store <= (done == DONE_STORE);
            rsp_rdata    <= (done == DONE_LOAD) ? ld_data : '0;
        end
    end

    a_r7_load_capture: assert property (@(posedge clk) disable iff (rst)
        (done == DONE_LOAD) |=> (rsp_valid && !rsp_error && rsp_rdata == $past(ld_data)));

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(rsp_valid)) |-> 1'b0);

endmodule

// File: rtl/ldst_req_port.sv
module ldst_req_port
    import ldst_req_pkg::*;
#(
    parameter int AW = 48,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic          cmd_is_store,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          rsp_valid,
    output logic          rsp_error,
    output logic          rsp_is_store,
    output logic [DW-1:0] rsp_rdata,
    output logic          prt_ld,
    output logic          prt_st,
    output logic          prt_die,
    output logic          prt_addr_vld,
    output logic [AW-1:0] prt_addr,
    output logic          prt_sdata_vld,
    output logic [DW-1:0] prt_sdata,
    input  logic          prt_busy,
    input  logic          prt_addr_ok,
    input  logic          prt_addr_exc,
    input  logic          prt_ld_ok,
    input  logic [DW-1:0] prt_ld_data
);

    logic       capture;
    logic       op_store;
    done_kind_e done;

    assign prt_die = rst;

    ldst_req_hold #(.AW(AW), .DW(DW)) u_hold (
        .clk           (clk),
        .rst           (rst),
        .capture       (capture),
        .in_is_store   (cmd_is_store),
        .in_addr       (cmd_addr),
        .in_wdata      (cmd_wdata),
        .hold_is_store (op_store),
        .hold_addr     (prt_addr),
        .hold_wdata    (prt_sdata)
    );

    ldst_req_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .op_store  (op_store),
        .busy      (prt_busy),
        .addr_ok   (prt_addr_ok),
        .addr_exc  (prt_addr_exc),
        .ld_ok     (prt_ld_ok),
        .cmd_ready (cmd_ready),
        .capture   (capture),
        .ld_strobe (prt_ld),
        .st_strobe (prt_st),
        .addr_vld  (prt_addr_vld),
        .sdata_vld (prt_sdata_vld),
        .done      (done)
    );

    ldst_req_resp #(.DW(DW)) u_resp (
        .clk          (clk),
        .rst          (rst),
        .done         (done),
        .ld_data      (prt_ld_data),
        .rsp_valid    (rsp_valid),
        .rsp_error    (rsp_error),
        .rsp_is_store (rsp_is_store),
        .rsp_rdata    (rsp_rdata)
    );

    a_r1_accept_not_busy: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |-> !prt_busy);

    a_r3_addr_held: assert property (@(posedge clk) disable iff (rst)
        (prt_addr_vld && prt_busy) |=> (prt_addr_vld && $stable(prt_addr)));

    a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
        (prt_ld || prt_st) |-> (prt_addr_vld && !(prt_ld && prt_st)));

    a_r8_store_done: assert property (@(posedge clk) disable iff (rst)
        (prt_addr_vld && !prt_ld && !prt_st && !prt_busy) |=> (rsp_valid && rsp_is_store));

endmodule

// File: tb/ldst_req_port_bench.sv
module ldst_req_port_bench;

    localparam int AW = 48;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic          cmd_is_store = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          rsp_valid, rsp_error, rsp_is_store;
    logic [DW-1:0] rsp_rdata;
    logic          prt_ld, prt_st, prt_die, prt_addr_vld, prt_sdata_vld;
    logic [AW-1:0] prt_addr;
    logic [DW-1:0] prt_sdata;
    logic          prt_busy, prt_addr_ok, prt_addr_exc, prt_ld_ok;
    logic [DW-1:0] prt_ld_data;

    always #5 clk = ~clk;

    ldst_req_port #(.AW(AW), .DW(DW)) u_ldst_req_port (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_is_store(cmd_is_store),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_error(rsp_error), .rsp_is_store(rsp_is_store),
        .rsp_rdata(rsp_rdata),
        .prt_ld(prt_ld), .prt_st(prt_st), .prt_die(prt_die),
        .prt_addr_vld(prt_addr_vld), .prt_addr(prt_addr),
        .prt_sdata_vld(prt_sdata_vld), .prt_sdata(prt_sdata),
        .prt_busy(prt_busy), .prt_addr_ok(prt_addr_ok), .prt_addr_exc(prt_addr_exc),
        .prt_ld_ok(prt_ld_ok), .prt_ld_data(prt_ld_data)
    );

    int tests = 0;
    int fails = 0;

    // ---------------- responder model ----------------
    typedef enum logic [1:0] {R_IDLE, R_ADDR, R_LDW, R_STW} rsp_st_e;
    rsp_st_e       r_state = R_IDLE;
    int            r_cnt = 0;
    logic          r_is_ld = 1'b0;
    logic          cfg_exc = 1'b0;
    int            cfg_adly = 0;
    int            cfg_ldly = 0;
    logic          force_busy = 1'b0;
    logic [DW-1:0] rmem [16];
    logic [DW-1:0] smem [16];
    logic [AW-1:0] cur_addr = '0;

    initial begin
        for (int i = 0; i < 16; i++) begin
            rmem[i] = 64'h0A5A_0000_0000_0000 | DW'(i * 17 + 3);
            smem[i] = 64'h0A5A_0000_0000_0000 | DW'(i * 17 + 3);
        end
    end

    assign prt_addr_ok  = (r_state == R_ADDR) && (r_cnt == 0) && !cfg_exc;
    assign prt_addr_exc = (r_state == R_ADDR) && (r_cnt == 0) && cfg_exc;
    assign prt_ld_ok    = (r_state == R_LDW) && (r_cnt == 0);
    assign prt_ld_data  = prt_ld_ok ? rmem[prt_addr[3:0]] : ~rmem[prt_addr[3:0]];
    assign prt_busy     = force_busy |
                          ((r_state == R_IDLE) ? (prt_ld | prt_st) : !(prt_addr_exc | prt_ld_ok));

    always @(posedge clk) begin
        if (rst) begin
            r_state <= R_IDLE;
        end else begin
            case (r_state)
                R_IDLE: if (prt_ld || prt_st) begin
                    r_is_ld <= prt_ld;
                    r_cnt   <= cfg_adly;
                    r_state <= R_ADDR;
                end
                R_ADDR: if (r_cnt == 0) begin
                    if (cfg_exc) r_state <= R_IDLE;
                    else if (r_is_ld) begin
                        r_cnt   <= cfg_ldly;
                        r_state <= R_LDW;
                    end else r_state <= R_STW;
                end else r_cnt <= r_cnt - 1;
                R_LDW: if (r_cnt == 0) r_state <= R_IDLE; else r_cnt <= r_cnt - 1;
                R_STW: if (prt_sdata_vld) begin
                    rmem[prt_addr[3:0]] <= prt_sdata;
                    r_state <= R_IDLE;
                end
                default: r_state <= R_IDLE;
            endcase
        end
    end

    // ---------------- protocol monitor ----------------
    always @(negedge clk) begin
        if (!rst) begin
            if (prt_ld && prt_st) begin
                fails++;
                $display("FAIL R2: both strobes high ld=%0b st=%0b expected one", prt_ld, prt_st);
            end
            if (r_state != R_IDLE && (!prt_addr_vld || prt_addr != cur_addr)) begin
                fails++;
                $display("FAIL R3: addr_vld=%0b addr=%h expected 1/%h", prt_addr_vld, prt_addr, cur_addr);
            end
            if (prt_sdata_vld && r_state != R_STW) begin
                fails++;
                $display("FAIL R5: store data pulse in responder state %0d expected after addr accept", r_state);
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic          st;
        logic          err;
        logic [DW-1:0] data;
        string         req;
    } exp_t;
    exp_t exp_q[$];

    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R10: unexpected completion st=%0b err=%0b data=%h expected none",
                         rsp_is_store, rsp_error, rsp_rdata);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rsp_is_store !== e.st || rsp_error !== e.err || rsp_rdata !== e.data) begin
                    fails++;
                    $display("FAIL %s: got st=%0b err=%0b data=%h expected st=%0b err=%0b data=%h",
                             e.req, rsp_is_store, rsp_error, rsp_rdata, e.st, e.err, e.data);
                end
            end
        end
    end

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, expv);
        end
    endtask

    // driver: one command, expected completion pushed into the queue
    task automatic issue(input logic st, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic exc, input int adly, input int ldly,
                         input string req, input int hold_cycles);
        exp_t e;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cfg_exc = exc; cfg_adly = adly; cfg_ldly = ldly;
        cur_addr = a;
        cmd_valid = 1'b1; cmd_is_store = st; cmd_addr = a; cmd_wdata = d;
        e.st   = st && !exc;
        e.err  = exc;
        e.data = (st || exc) ? '0 : smem[a[3:0]];
        e.req  = req;
        exp_q.push_back(e);
        if (st && !exc) smem[a[3:0]] = d;
        @(negedge clk);
        // R1: extra valid during the transaction must be ignored
        for (int k = 0; k < hold_cycles; k++) begin
            cmd_addr = ~a; cmd_wdata = ~d; cmd_is_store = ~st;
            check("R1 ready low in transaction", DW'(cmd_ready), '0);
            @(negedge clk);
        end
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    logic run_done = 1'b0;

    initial begin
        // R9: reset state and die
        repeat (3) @(negedge clk);
        check("R9 die during reset", DW'(prt_die), 1);
        rst = 1'b0;
        @(negedge clk);
        check("R9 die after reset", DW'(prt_die), 0);
        check("R9 idle ready", DW'(cmd_ready), 1);
        check("R9 strobes low", DW'({prt_ld, prt_st, prt_addr_vld, prt_sdata_vld, rsp_valid}), 0);

        // R5 R8 store, R7 load of stored data, zero delays (R4)
        issue(1'b1, 48'h0000_1234_5672, 64'hDEAD_BEEF_0000_0001, 1'b0, 0, 0, "R8 store", 0);
        issue(1'b0, 48'h0000_1234_5672, '0, 1'b0, 0, 0, "R7 load after store", 0);
        // R4 R7 delayed accept and delayed data
        issue(1'b0, 48'h0000_0000_0009, '0, 1'b0, 4, 6, "R7 load delayed", 0);
        issue(1'b1, 48'h0000_0000_0003, 64'h0123_4567_89AB_CDEF, 1'b0, 3, 0, "R8 store delayed", 0);
        issue(1'b0, 48'h0000_0000_0003, '0, 1'b0, 1, 2, "R7 load stored", 0);
        // R6 exceptions on load and store
        issue(1'b0, 48'h7FFF_0000_0005, '0, 1'b1, 2, 0, "R6 load exception", 0);
        issue(1'b1, 48'h7FFF_0000_0006, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 0, 0, "R6 store exception", 0);
        issue(1'b0, 48'h0000_0000_0006, '0, 1'b0, 0, 1, "R6 store exception left memory", 0);
        // R10 back-to-back stores to one address, then load
        issue(1'b1, 48'h0000_0000_000C, 64'h1111_1111_1111_1111, 1'b0, 0, 0, "R8 store b2b a", 0);
        issue(1'b1, 48'h0000_0000_000C, 64'h2222_2222_2222_2222, 1'b0, 0, 0, "R8 store b2b b", 0);
        issue(1'b0, 48'h0000_0000_000C, '0, 1'b0, 0, 0, "R10 load last store", 0);
        // R1 valid held during a long transaction
        issue(1'b0, 48'h0000_0000_000E, '0, 1'b0, 5, 3, "R1 load with held valid", 2);
        drain();

        // R1: responder busy while idle blocks acceptance
        @(negedge clk);
        force_busy = 1'b1;
        cmd_valid = 1'b1; cmd_is_store = 1'b0; cmd_addr = 48'h1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R1 ready low when busy", DW'(cmd_ready), 0);
            check("R1 no strobe when busy", DW'({prt_ld, prt_st, prt_addr_vld}), 0);
        end
        cmd_valid = 1'b0;
        @(negedge clk);
        force_busy = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 no stray completion", DW'(exp_q.size()), 0);
        check("R9 idle ready again", DW'(cmd_ready), 1);

        run_done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!run_done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule